// File: doc/BRIEF.md
# Framed Message Receive Parser

This block sits behind a UART receiver and turns a stream of bytes, one per valid strobe, into framed command messages. A frame begins with a start flag. Next come an address byte, a message ID byte, an operation-type byte and a two-byte payload length. The payload, a one-byte CRC and an end flag follow. Payload bytes are passed straight to a temporary buffer through a write strobe and data bus. The parser only counts them. The header fields are kept in output registers.

When the end flag arrives, the parser compares the received CRC with the CRC it has computed and checks the flag itself. A good frame produces a one-cycle commit pulse, and the header fields are valid at that point. The parser then waits for the downstream copy to finish and the reply encoder to finish before it accepts another frame. A bad frame produces a one-cycle error pulse and a flush of the temporary buffer. A frame that stalls for longer than a programmable number of cycles is dropped, with a timeout pulse and a flush.

Top module: `frame_rx_parser`

## Requirements
- R1: In the idle state only a byte equal to the start flag (default 0xA5) opens a frame; any other byte in idle causes no buffer write and no pulse on commit, frame_err or tmo_abort.
- R2: After the start flag, bytes are taken in this order: address, ID, type, length high byte, length low byte (length is most significant byte first). meta_addr, meta_id, meta_type and meta_len hold these values when commit is high.
- R3: Each valid payload byte asserts tbuf_wr_en in the same cycle with tbuf_wr_data equal to that byte. Exactly meta_len payload bytes are written. A length of zero goes straight to the CRC byte with no writes.
- R4: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00, shifted most significant bit first over address, ID, type, both length bytes and the payload. If the received CRC matches and the final byte equals the end flag (default 0x5A), commit is high for exactly one cycle, the cycle after the end byte.
- R5: A CRC mismatch or a wrong end byte raises frame_err and tbuf_flush together for exactly one cycle, the cycle after the final byte. Any byte in that cycle is ignored, and the parser then returns to idle.
- R6: If TMO_CYCLES consecutive cycles pass with no valid byte while a frame is open (start flag through end byte), tmo_abort and tbuf_flush pulse for one cycle and the parser returns to idle without an error pulse. A byte that arrives after a gap of TMO_CYCLES-1 idle cycles is accepted.
- R7: meta_op decodes the type byte: 0x01 gives 1 (set), 0x02 gives 2 (query), 0x03 gives 3 (sort), any other value gives 0.
- R8: After commit, all received bytes are ignored (no writes, no new frame) until copy_done is seen and then enc_done is seen, in that order. enc_done before copy_done has no effect, and no timeout fires while waiting.
- R9: During and right after reset, tbuf_wr_en, tbuf_flush, commit, frame_err and tmo_abort are low and all metadata outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| copy_done | input | 1 | Temporary buffer copy finished |
| enc_done | input | 1 | Reply encoder finished |
| tbuf_wr_en | output | 1 | Temporary buffer write strobe |
| tbuf_wr_data | output | 8 | Temporary buffer write data |
| tbuf_flush | output | 1 | Discard the temporary buffer contents |
| commit | output | 1 | Good frame pulse |
| frame_err | output | 1 | CRC or end-flag error pulse |
| tmo_abort | output | 1 | Stalled-frame abort pulse |
| meta_addr | output | 8 | Captured address byte |
| meta_id | output | 8 | Captured message ID |
| meta_type | output | 8 | Captured type byte |
| meta_op | output | 2 | Decoded operation (0 none, 1 set, 2 query, 3 sort) |
| meta_len | output | 16 | Captured payload length |

## Verification
The bench builds the parser with TMO_CYCLES set to 24 and keeps the default flags, polynomial and initial value. A 24-cycle window lets the bench reach both sides of the timeout edge: a gap one cycle short of the limit, which must be accepted, and a gap that meets it, which must abort the frame. The bench also holds the parser in the copy wait state for longer than that window. A 258-byte payload checks that the length is taken high byte first and that the payload counter carries across its low byte.

// File: rtl/frx_pkg.sv
package frx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ID,
      ST_TYPE,
      ST_LENH,
      ST_LENL,
      ST_PAY,
      ST_CRC,
      ST_EOF,
      ST_ERR,
      ST_WCOPY,
      ST_WENC
   } frx_state_e;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_SET   = 2'd1,
      OP_QUERY = 2'd2,
      OP_SORT  = 2'd3
   } frx_op_e;

   localparam logic [7:0] TYPE_CODE_SET   = 8'h01;
   localparam logic [7:0] TYPE_CODE_QUERY = 8'h02;
   localparam logic [7:0] TYPE_CODE_SORT  = 8'h03;

   function automatic frx_op_e decode_op(input logic [7:0] code);
      frx_op_e op;
      unique case (code)
         TYPE_CODE_SET:   op = OP_SET;
         TYPE_CODE_QUERY: op = OP_QUERY;
         TYPE_CODE_SORT:  op = OP_SORT;
         default:         op = OP_NONE;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/frx_crc8.sv
module frx_crc8 #(
   parameter logic [7:0] POLY = 8'h07,
   parameter logic [7:0] INIT = 8'h00,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              en,
   input  logic [DATA_W-1:0] din,
   output logic [7:0]        crc
);
   logic [7:0] crc_q;
   logic [7:0] chain [0:DATA_W];

   assign chain[0] = crc_q;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic fb;
      assign fb = chain[i][7] ^ din[DATA_W-1-i];
      assign chain[i+1] = {chain[i][6:0], 1'b0} ^ (fb ? POLY : 8'h00);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= INIT;
      else if (clear) crc_q <= INIT;
      else if (en)    crc_q <= chain[DATA_W];
   end

   assign crc = crc_q;
endmodule

// File: rtl/frx_gap_timer.sv
module frx_gap_timer #(
   parameter int unsigned LIMIT = 60000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic byte_seen,
   output logic expire
);
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (!armed || byte_seen) cnt_q <= '0;
      else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
   end

   assign expire = armed && !byte_seen && (cnt_q == LAST);
endmodule

// File: rtl/frx_pay_count.sv
module frx_pay_count #(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   input  logic [LEN_W-1:0] len,
   output logic             last
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W:0]   next_cnt;

   assign next_cnt = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (inc)   cnt_q <= next_cnt[LEN_W-1:0];
   end

   assign last = (next_cnt == {1'b0, len});
endmodule

// File: rtl/frame_rx_parser.sv
module frame_rx_parser
   import frx_pkg::*;
#(
   parameter logic [7:0]  SOF_FLAG   = 8'hA5,
   parameter logic [7:0]  EOF_FLAG   = 8'h5A,
   parameter logic [7:0]  CRC_POLY   = 8'h07,
   parameter logic [7:0]  CRC_INIT   = 8'h00,
   parameter int unsigned TMO_CYCLES = 60000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic        copy_done,
   input  logic        enc_done,
   output logic        tbuf_wr_en,
   output logic [7:0]  tbuf_wr_data,
   output logic        tbuf_flush,
   output logic        commit,
   output logic        frame_err,
   output logic        tmo_abort,
   output logic [7:0]  meta_addr,
   output logic [7:0]  meta_id,
   output logic [7:0]  meta_type,
   output logic [1:0]  meta_op,
   output logic [15:0] meta_len
);
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned LEN_W  = 2 * BYTE_W;

   if (TMO_CYCLES < 2) begin : g_bad_tmo
      $error("TMO_CYCLES must be at least 2");
   end
   if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
      $error("CRC_POLY must have its constant term set");
   end
   if (SOF_FLAG == EOF_FLAG) begin : g_bad_flags
      $error("start and end flags must differ");
   end

   frx_state_e st_q, st_d;

   logic [7:0]       addr_q, id_q, type_q, crc_rx_q;
   logic [LEN_W-1:0] len_q;
   frx_op_e          op_q;
   logic             commit_q, tmo_q;

   logic             in_frame, tmo_fire, frame_good, pay_last;
   logic             crc_en, crc_clr;
   logic [7:0]       crc_acc;
   logic [LEN_W-1:0] len_full;

   assign in_frame = (st_q == ST_ADDR) || (st_q == ST_ID)  || (st_q == ST_TYPE) ||
                     (st_q == ST_LENH) || (st_q == ST_LENL) || (st_q == ST_PAY)  ||
                     (st_q == ST_CRC)  || (st_q == ST_EOF);

   assign crc_clr = (st_q == ST_IDLE);
   assign crc_en  = rx_valid &&
                    ((st_q == ST_ADDR) || (st_q == ST_ID)   || (st_q == ST_TYPE) ||
                     (st_q == ST_LENH) || (st_q == ST_LENL) || (st_q == ST_PAY));

   assign len_full   = {len_q[LEN_W-1:BYTE_W], rx_byte};
   assign frame_good = (rx_byte == EOF_FLAG) && (crc_rx_q == crc_acc);

   frx_crc8 #(
      .POLY   (CRC_POLY),
      .INIT   (CRC_INIT),
      .DATA_W (BYTE_W)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (crc_clr),
      .en    (crc_en),
      .din   (rx_byte),
      .crc   (crc_acc)
   );

   frx_gap_timer #(
      .LIMIT (TMO_CYCLES)
   ) u_gap (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (in_frame),
      .byte_seen (rx_valid),
      .expire    (tmo_fire)
   );

   frx_pay_count #(
      .LEN_W (LEN_W)
   ) u_pay (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (st_q == ST_LENL),
      .inc   ((st_q == ST_PAY) && rx_valid),
      .len   (len_q),
      .last  (pay_last)
   );

   always_comb begin
      st_d = st_q;
      if (tmo_fire) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:  if (rx_valid && rx_byte == SOF_FLAG) st_d = ST_ADDR;
            ST_ADDR:  if (rx_valid) st_d = ST_ID;
            ST_ID:    if (rx_valid) st_d = ST_TYPE;
            ST_TYPE:  if (rx_valid) st_d = ST_LENH;
            ST_LENH:  if (rx_valid) st_d = ST_LENL;
            ST_LENL:  if (rx_valid) st_d = (len_full == '0) ? ST_CRC : ST_PAY;
            ST_PAY:   if (rx_valid && pay_last) st_d = ST_CRC;
            ST_CRC:   if (rx_valid) st_d = ST_EOF;
            ST_EOF:   if (rx_valid) st_d = frame_good ? ST_WCOPY : ST_ERR;
            ST_ERR:   st_d = ST_IDLE;
            ST_WCOPY: if (copy_done) st_d = ST_WENC;
            ST_WENC:  if (enc_done) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         commit_q <= 1'b0;
         tmo_q    <= 1'b0;
      end else begin
         st_q     <= st_d;
         commit_q <= (st_q == ST_EOF) && rx_valid && frame_good;
         tmo_q    <= tmo_fire;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         id_q     <= '0;
         type_q   <= '0;
         op_q     <= OP_NONE;
         len_q    <= '0;
         crc_rx_q <= '0;
      end else if (rx_valid) begin
         unique case (st_q)
            ST_ADDR: addr_q <= rx_byte;
            ST_ID:   id_q   <= rx_byte;
            ST_TYPE: begin
               type_q <= rx_byte;
               op_q   <= decode_op(rx_byte);
            end
            ST_LENH: len_q[LEN_W-1:BYTE_W] <= rx_byte;
            ST_LENL: len_q[BYTE_W-1:0]     <= rx_byte;
            ST_CRC:  crc_rx_q <= rx_byte;
            default: ;
         endcase
      end
   end

   assign tbuf_wr_en   = (st_q == ST_PAY) && rx_valid;
   assign tbuf_wr_data = rx_byte;
   assign frame_err    = (st_q == ST_ERR);
   assign tbuf_flush   = (st_q == ST_ERR) || tmo_q;
   assign commit       = commit_q;
   assign tmo_abort    = tmo_q;
   assign meta_addr    = addr_q;
   assign meta_id      = id_q;
   assign meta_type    = type_q;
   assign meta_op      = op_q;
   assign meta_len     = len_q;
endmodule

// File: rtl/frame_rx_parser_chk.sv
module frame_rx_parser_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic       tbuf_wr_en,
   input logic       tbuf_flush,
   input logic       commit,
   input logic       frame_err,
   input logic       tmo_abort,
   input logic [7:0] meta_type,
   input logic [1:0] meta_op
);
   // R1
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({commit, frame_err, tmo_abort}));

   // R3
   wr_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbuf_wr_en |-> rx_valid);

   // R4
   commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);

   // R5
   err_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> tbuf_flush);

   // R5
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   // R6
   tmo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_abort |-> (tbuf_flush && !frame_err));

   // R6
   tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_abort |=> !tmo_abort);

   // R7
   op_sort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> ((meta_op == 2'd3) == (meta_type == 8'h03)));

   // R7
   op_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> ((meta_op == 2'd1) == (meta_type == 8'h01)));

   // R8
   no_wr_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !tbuf_wr_en);
endmodule

bind frame_rx_parser frame_rx_parser_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .tbuf_wr_en (tbuf_wr_en),
   .tbuf_flush (tbuf_flush),
   .commit     (commit),
   .frame_err  (frame_err),
   .tmo_abort  (tmo_abort),
   .meta_type  (meta_type),
   .meta_op    (meta_op)
);

// File: tb/frame_rx_parser_test.sv
module frame_rx_parser_test;
   localparam int TMO = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        copy_done = 1'b0;
   logic        enc_done = 1'b0;
   logic        tbuf_wr_en, tbuf_flush, commit, frame_err, tmo_abort;
   logic [7:0]  tbuf_wr_data, meta_addr, meta_id, meta_type;
   logic [1:0]  meta_op;
   logic [15:0] meta_len;

   always #4 clk = ~clk;

   frame_rx_parser #(.TMO_CYCLES(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .copy_done(copy_done), .enc_done(enc_done),
      .tbuf_wr_en(tbuf_wr_en), .tbuf_wr_data(tbuf_wr_data), .tbuf_flush(tbuf_flush),
      .commit(commit), .frame_err(frame_err), .tmo_abort(tmo_abort),
      .meta_addr(meta_addr), .meta_id(meta_id), .meta_type(meta_type),
      .meta_op(meta_op), .meta_len(meta_len));

   int n_cmp = 0;
   int n_bad = 0;

   // behavioural reference: phase 0 idle, 1..5 header, 6 payload, 7 crc, 8 end,
   // 9 error, 10 wait copy, 11 wait encoder
   int          ph = 0, idle = 0, pcnt = 0;
   logic [7:0]  m_addr = 0, m_id = 0, m_type = 0, m_crcrx = 0;
   logic [15:0] m_len = 0;
   logic [1:0]  m_op = 0;
   logic        e_commit = 0, e_tmo = 0;
   logic [7:0]  body[$];
   logic [7:0]  fq[$];

   function automatic logic [7:0] ref_crc(input logic [7:0] q[$]);
      logic [7:0] c = 8'h00;
      foreach (q[k]) begin
         c = c ^ q[k];
         for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_step(input logic v, input logic [7:0] b, input logic cd, input logic ed);
      bit inf;
      e_commit = 0;
      e_tmo = 0;
      inf = (ph >= 1 && ph <= 8);
      if (inf && !v) begin
         idle++;
         if (idle == TMO) begin
            ph = 0; idle = 0; e_tmo = 1;
            return;
         end
      end else idle = 0;
      case (ph)
         0: if (v && b == 8'hA5) begin ph = 1; body.delete(); end
         1: if (v) begin m_addr = b; body.push_back(b); ph = 2; end
         2: if (v) begin m_id = b; body.push_back(b); ph = 3; end
         3: if (v) begin
               m_type = b; body.push_back(b); ph = 4;
               m_op = (b == 8'h01) ? 2'd1 : (b == 8'h02) ? 2'd2 : (b == 8'h03) ? 2'd3 : 2'd0;
            end
         4: if (v) begin m_len[15:8] = b; body.push_back(b); ph = 5; end
         5: if (v) begin
               m_len[7:0] = b; body.push_back(b); pcnt = 0;
               ph = (m_len == 0) ? 7 : 6;
            end
         6: if (v) begin body.push_back(b); pcnt++; if (pcnt == int'(m_len)) ph = 7; end
         7: if (v) begin m_crcrx = b; ph = 8; end
         8: if (v) begin
               if (b == 8'h5A && m_crcrx == ref_crc(body)) begin ph = 10; e_commit = 1; end
               else ph = 9;
            end
         9: ph = 0;
         10: if (cd) ph = 11;
         11: if (ed) ph = 0;
         default: ph = 0;
      endcase
   endtask

   task automatic cyc(input logic v, input logic [7:0] b, input logic cd, input logic ed,
                      input string tag);
      bit wr;
      rx_valid = v; rx_byte = b; copy_done = cd; enc_done = ed;
      #1;
      wr = (ph == 6) && v;
      chk({tag, " R3"}, "tbuf_wr_en", tbuf_wr_en, wr);
      if (wr) chk({tag, " R3"}, "tbuf_wr_data", tbuf_wr_data, b);
      model_step(v, b, cd, ed);
      @(negedge clk);
      chk({tag, " R4"}, "commit", commit, e_commit);
      chk({tag, " R5"}, "frame_err", frame_err, ph == 9);
      chk({tag, " R5"}, "tbuf_flush", tbuf_flush, (ph == 9) || e_tmo);
      chk({tag, " R6"}, "tmo_abort", tmo_abort, e_tmo);
      chk({tag, " R2"}, "meta_addr", meta_addr, m_addr);
      chk({tag, " R2"}, "meta_id", meta_id, m_id);
      chk({tag, " R2"}, "meta_type", meta_type, m_type);
      chk({tag, " R2"}, "meta_len", meta_len, m_len);
      chk({tag, " R7"}, "meta_op", meta_op, m_op);
   endtask

   task automatic idle_cycles(input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 1'b0, 1'b0, tag);
   endtask

   task automatic build(input logic [7:0] a, input logic [7:0] id, input logic [7:0] ty,
                        input int len, input int seed, input logic [7:0] crc_flip,
                        input logic [7:0] eof);
      logic [7:0] hb[$];
      hb.delete();
      hb.push_back(a); hb.push_back(id); hb.push_back(ty);
      hb.push_back(8'(len >> 8)); hb.push_back(8'(len));
      for (int k = 0; k < len; k++) hb.push_back(8'(k * 7 + seed));
      fq.delete();
      fq.push_back(8'hA5);
      foreach (hb[k]) fq.push_back(hb[k]);
      fq.push_back(ref_crc(hb) ^ crc_flip);
      fq.push_back(eof);
   endtask

   task automatic feed(input int gap, input string tag);
      foreach (fq[k]) begin
         cyc(1'b1, fq[k], 1'b0, 1'b0, tag);
         if (k != fq.size() - 1) idle_cycles(gap, tag);
      end
   endtask

   task automatic handshake(input string tag);
      idle_cycles(1, tag);
      cyc(1'b0, 8'h00, 1'b1, 1'b0, tag);
      cyc(1'b0, 8'h00, 1'b0, 1'b1, tag);
      idle_cycles(1, tag);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9", "tbuf_wr_en", tbuf_wr_en, 0);
      chk("R9", "pulses", {commit, frame_err, tmo_abort, tbuf_flush}, 0);
      chk("R9", "meta", {meta_addr, meta_id, meta_type, meta_op, meta_len}, 0);
      rst_n = 1'b1;
      idle_cycles(2, "R9");

      // R1: bytes other than the start flag in idle
      cyc(1'b1, 8'h00, 1'b0, 1'b0, "R1");
      cyc(1'b1, 8'h5A, 1'b0, 1'b0, "R1");
      cyc(1'b1, 8'hFF, 1'b0, 1'b0, "R1");
      idle_cycles(2, "R1");

      // R2 R3 R4: good sort frame, back-to-back bytes
      build(8'h12, 8'h34, 8'h03, 3, 5, 8'h00, 8'h5A);
      feed(0, "R4");
      // R8: ignored bytes and early enc_done while waiting for the copy
      cyc(1'b1, 8'hA5, 1'b0, 1'b0, "R8");
      cyc(1'b0, 8'h00, 1'b0, 1'b1, "R8");
      idle_cycles(TMO + 4, "R8");
      cyc(1'b0, 8'h00, 1'b1, 1'b0, "R8");
      cyc(1'b1, 8'hA5, 1'b0, 1'b0, "R8");
      cyc(1'b1, 8'h11, 1'b0, 1'b0, "R8");
      cyc(1'b0, 8'h00, 1'b0, 1'b1, "R8");
      idle_cycles(2, "R8");

      // R7 R3: zero-length set, query with gaps, unknown type
      build(8'h01, 8'h02, 8'h01, 0, 0, 8'h00, 8'h5A);
      feed(1, "R7");
      handshake("R7");
      build(8'hC0, 8'h03, 8'h02, 2, 9, 8'h00, 8'h5A);
      feed(2, "R7");
      handshake("R7");
      build(8'hC1, 8'h04, 8'h07, 1, 3, 8'h00, 8'h5A);
      feed(0, "R7");
      handshake("R7");

      // R5: bad CRC, then a start flag in the error cycle is dropped
      build(8'h22, 8'h05, 8'h03, 4, 1, 8'h01, 8'h5A);
      feed(0, "R5");
      cyc(1'b1, 8'hA5, 1'b0, 1'b0, "R5");
      idle_cycles(2, "R5");
      // R5: wrong end flag
      build(8'h23, 8'h06, 8'h03, 2, 2, 8'h00, 8'h5B);
      feed(0, "R5");
      idle_cycles(2, "R5");

      // R6: stall inside the header aborts
      build(8'h30, 8'h07, 8'h03, 2, 4, 8'h00, 8'h5A);
      fq = fq[0:2];
      feed(0, "R6");
      idle_cycles(TMO + 3, "R6");
      // R6: stall inside the payload aborts
      build(8'h31, 8'h08, 8'h03, 6, 4, 8'h00, 8'h5A);
      fq = fq[0:7];
      feed(0, "R6");
      idle_cycles(TMO + 2, "R6");
      // R6: gap one short of the limit is tolerated
      build(8'h32, 8'h09, 8'h02, 1, 6, 8'h00, 8'h5A);
      feed(TMO - 1, "R6");
      handshake("R6");

      // R2 R3: length above 255, high byte first
      build(8'h40, 8'h0A, 8'h03, 258, 11, 8'h00, 8'h5A);
      feed(0, "R2");
      handshake("R2");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule